// File: doc/BRIEF.md
# Key-Sequence Serviced Watchdog

This block is a watchdog timer for a processor subsystem. While it is enabled, a counter advances by one on every clock edge. Software keeps it from expiring by writing a two-byte key to a dedicated service register. The key is first 0x55 and then 0xAA. The 0xAA write restarts the count, but only if a 0x55 came before it. If the counter reaches the selected limit before a good key arrives, the block raises a reset request. A write of any byte that is not one of the two keys also raises a reset request.

A 2-bit select field picks the timeout. The choices are three power-of-two lengths, and a fourth code turns the watchdog off. With the default parameters the lengths are 16, 64 and 256 cycles. The output is a single-cycle request pulse meant for the chip's reset sequencer. Each request clears the counter and the key progress inside the block.

Top module: `keyWatchdog`

## Requirements
- R1: When `wdEnable` is low or `tmoSel` is 0, the block raises no request, whatever is written, and its counter and key progress are held cleared.
- R2: Timeout length depends on `tmoSel`: code 1 gives 2^BASE_LOG cycles, code 2 gives 2^(BASE_LOG+STEP_LOG) and code 3 gives 2^(BASE_LOG+2*STEP_LOG). The defaults give 16, 64 and 256. Counting from the first active edge, or from the last restart, `rstReq` is high right after edge number N, where N is the selected length.
- R3: A service write of 0x55 followed later by a service write of 0xAA restarts the count at the 0xAA edge. The next timeout request then comes N edges after that edge.
- R4: Clock cycles with `svcWr` low, whatever `svcData` carries, may pass between the two key writes without breaking the sequence.
- R5: A 0xAA write with no 0x55 before it does not restart the count.
- R6: A repeated 0x55 write keeps the sequence armed, so a following 0xAA still restarts the count.
- R7: A service write of any byte other than 0x55 or 0xAA raises `rstReq` right after that write's edge, even when the sequence is armed.
- R8: When a completing 0xAA write lands on the same edge the timeout would fire, the restart wins and no request is raised.
- R9: `rstReq` is a one-cycle pulse and is never high on two consecutive cycles.
- R10: An active-low reset clears the counter, the key progress and `rstReq`.
- R11: Every request clears the counter and the key progress. The next timeout follows N edges later, and a 0xAA written after the request does not complete a 0x55 written before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wdEnable | input | 1 | Watchdog enable |
| tmoSel | input | 2 | Timeout select; 0 turns the watchdog off |
| svcWr | input | 1 | Write strobe for the service register |
| svcData | input | 8 | Byte written to the service register |
| rstReq | output | 1 | One-cycle reset request pulse |

## Verification
The hardest case to reach from the ports is a completing 0xAA write that lands on exactly the edge where the counter hits its limit. There the restart and the timeout compete in the same cycle. The stimulus counts edges from reset release and places the 0xAA write on edge N. It then expects the first request a full period later, not at that edge. The clearing of key progress by a request or by reset is also invisible at the ports. To reach it, the bench arms the sequence, lets a request or a reset occur, and then writes 0xAA alone; the request must come from the timeout and not from a restart.

// File: rtl/wdogPkg.sv
package wdogPkg;
  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_DONE = 8'hAA;

  typedef struct packed {
    logic cntClear;
    logic cntRun;
  } wdStrobe_t;
endpackage

// File: rtl/wdogDatapath.sv
module wdogDatapath
  import wdogPkg::*;
#(
  parameter int BASE_LOG = 4,
  parameter int STEP_LOG = 2,
  parameter int CNT_W    = BASE_LOG + 2 * STEP_LOG
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdStrobe_t        strobe,
  input  logic [1:0]       tmoSel,
  output logic [CNT_W-1:0] cntVal,
  output logic             timeoutHit
);
  localparam int NUM_SEL = 4;

  logic [CNT_W-1:0] lastCount [NUM_SEL];

  generate
    for (genvar s = 0; s < NUM_SEL; s++) begin : g_limit
      if (s == 0) begin : g_off
        assign lastCount[s] = '1;
      end else begin : g_on
        localparam int LEN_LOG = BASE_LOG + (s - 1) * STEP_LOG;
        assign lastCount[s] = CNT_W'((64'd1 << LEN_LOG) - 64'd1);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal <= '0;
    end else if (strobe.cntClear) begin
      cntVal <= '0;
    end else if (strobe.cntRun) begin
      cntVal <= cntVal + 1'b1;
    end
  end

  always_comb begin
    timeoutHit = (cntVal >= lastCount[tmoSel]);
  end
endmodule

// File: rtl/wdogCtrl.sv
module wdogCtrl
  import wdogPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wdEnable,
  input  logic [1:0] tmoSel,
  input  logic       svcWr,
  input  logic [7:0] svcData,
  input  logic       timeoutHit,
  output wdStrobe_t  strobe,
  output logic       armedFlag,
  output logic       rstReq
);
  logic active;
  logic isArm;
  logic isDone;
  logic badWrite;
  logic restartNow;
  logic fire;

  always_comb begin
    active     = wdEnable && (tmoSel != 2'd0);
    isArm      = (svcData == KEY_ARM);
    isDone     = (svcData == KEY_DONE);
    badWrite   = active && svcWr && !isArm && !isDone;
    restartNow = active && svcWr && isDone && armedFlag;
    fire       = badWrite || (active && timeoutHit && !restartNow);
    strobe.cntRun   = active;
    strobe.cntClear = !active || fire || restartNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedFlag <= 1'b0;
    end else if (!active || fire || restartNow) begin
      armedFlag <= 1'b0;
    end else if (svcWr && isArm) begin
      armedFlag <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstReq <= 1'b0;
    end else begin
      rstReq <= fire && !rstReq;
    end
  end
endmodule

// File: rtl/keyWatchdog.sv
module keyWatchdog
  import wdogPkg::*;
#(
  parameter int BASE_LOG = 4,
  parameter int STEP_LOG = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wdEnable,
  input  logic [1:0] tmoSel,
  input  logic       svcWr,
  input  logic [7:0] svcData,
  output logic       rstReq
);
  localparam int CNT_W = BASE_LOG + 2 * STEP_LOG;

  wdStrobe_t        strobe;
  logic [CNT_W-1:0] cntVal;
  logic             timeoutHit;
  logic             armedFlag;

  wdogCtrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wdEnable  (wdEnable),
    .tmoSel    (tmoSel),
    .svcWr     (svcWr),
    .svcData   (svcData),
    .timeoutHit(timeoutHit),
    .strobe    (strobe),
    .armedFlag (armedFlag),
    .rstReq    (rstReq)
  );

  wdogDatapath #(
    .BASE_LOG(BASE_LOG),
    .STEP_LOG(STEP_LOG),
    .CNT_W   (CNT_W)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .tmoSel    (tmoSel),
    .cntVal    (cntVal),
    .timeoutHit(timeoutHit)
  );
endmodule

// File: rtl/wdogChecker.sv
module wdogChecker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             wdEnable,
  input logic [1:0]       tmoSel,
  input logic             svcWr,
  input logic [7:0]       svcData,
  input logic             rstReq,
  input logic [CNT_W-1:0] cntVal,
  input logic             armedFlag
);
  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq);

  // R7
  bad_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wdEnable && tmoSel != 2'd0 && svcWr && svcData != 8'h55 &&
     svcData != 8'hAA && !rstReq) |=> rstReq);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wdEnable && tmoSel != 2'd0) |=> !rstReq);

  // R11
  req_clears_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> (cntVal == '0));

  // R11
  req_clears_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> !armedFlag);
endmodule

bind keyWatchdog wdogChecker #(.CNT_W(CNT_W)) i_wdogChecker (
  .clk      (clk),
  .rstN     (rstN),
  .wdEnable (wdEnable),
  .tmoSel   (tmoSel),
  .svcWr    (svcWr),
  .svcData  (svcData),
  .rstReq   (rstReq),
  .cntVal   (cntVal),
  .armedFlag(armedFlag)
);

// File: tb/test_keyWatchdog.sv
module test_keyWatchdog;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_EDGES  = 300;

  typedef struct packed {
    logic        en;
    logic [1:0]  sel;
    logic [7:0]  d1;
    logic [15:0] e1;
    logic [7:0]  d2;
    logic [15:0] e2;
    logic [7:0]  d3;
    logic [15:0] e3;
    logic [15:0] expFirst;
    logic [7:0]  req;
  } vec_t;

  localparam int NUM_VEC = 14;
  localparam vec_t VECS [NUM_VEC] = '{
    '{1'b1, 2'd1, 8'h55, 16'd3,  8'hAA, 16'd5,  8'h00, 16'd0, 16'd21,  8'd3},  // R3
    '{1'b1, 2'd1, 8'hAA, 16'd3,  8'h55, 16'd5,  8'h00, 16'd0, 16'd16,  8'd5},  // R5
    '{1'b1, 2'd1, 8'h55, 16'd3,  8'h55, 16'd5,  8'hAA, 16'd7, 16'd23,  8'd6},  // R6
    '{1'b1, 2'd1, 8'h55, 16'd3,  8'hAA, 16'd12, 8'h00, 16'd0, 16'd28,  8'd4},  // R4
    '{1'b1, 2'd1, 8'h12, 16'd3,  8'h00, 16'd0,  8'h00, 16'd0, 16'd3,   8'd7},  // R7
    '{1'b1, 2'd1, 8'h55, 16'd3,  8'h00, 16'd5,  8'h00, 16'd0, 16'd5,   8'd7},  // R7
    '{1'b1, 2'd1, 8'h55, 16'd3,  8'hFF, 16'd5,  8'h00, 16'd0, 16'd5,   8'd7},  // R7
    '{1'b1, 2'd2, 8'h55, 16'd3,  8'hAA, 16'd5,  8'h00, 16'd0, 16'd69,  8'd2},  // R2
    '{1'b1, 2'd3, 8'h55, 16'd3,  8'hAA, 16'd5,  8'h00, 16'd0, 16'd261, 8'd2},  // R2
    '{1'b1, 2'd2, 8'h00, 16'd0,  8'h00, 16'd0,  8'h00, 16'd0, 16'd64,  8'd2},  // R2
    '{1'b1, 2'd1, 8'h55, 16'd3,  8'hAA, 16'd16, 8'h00, 16'd0, 16'd32,  8'd8},  // R8
    '{1'b1, 2'd0, 8'h12, 16'd3,  8'h00, 16'd0,  8'h00, 16'd0, 16'd0,   8'd1},  // R1
    '{1'b0, 2'd1, 8'h12, 16'd3,  8'h55, 16'd5,  8'h00, 16'd0, 16'd0,   8'd1},  // R1
    '{1'b1, 2'd3, 8'hAA, 16'd3,  8'h00, 16'd0,  8'h00, 16'd0, 16'd256, 8'd5}   // R5
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wdEnable = 1'b0;
  logic [1:0] tmoSel = 2'd0;
  logic       svcWr = 1'b0;
  logic [7:0] svcData = 8'h3C;
  logic       rstReq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  keyWatchdog i_keyWatchdog (
    .clk     (clk),
    .rstN    (rstN),
    .wdEnable(wdEnable),
    .tmoSel  (tmoSel),
    .svcWr   (svcWr),
    .svcData (svcData),
    .rstReq  (rstReq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset(input logic en, input logic [1:0] sel);
    @(negedge clk);
    rstN     = 1'b0;
    svcWr    = 1'b0;
    wdEnable = en;
    tmoSel   = sel;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic runSeq(input logic [7:0] d1, input int e1,
                        input logic [7:0] d2, input int e2,
                        input logic [7:0] d3, input int e3,
                        input int maxE,
                        output int firstE, output int secondE, output int dbl);
    logic prevReq;
    firstE  = 0;
    secondE = 0;
    dbl     = 0;
    prevReq = 1'b0;
    for (int e = 1; e <= maxE; e++) begin
      if (e == e1) begin
        svcWr = 1'b1; svcData = d1;
      end else if (e == e2) begin
        svcWr = 1'b1; svcData = d2;
      end else if (e == e3) begin
        svcWr = 1'b1; svcData = d3;
      end else begin
        svcWr = 1'b0; svcData = 8'h3C + 8'(e);
      end
      @(posedge clk);
      @(negedge clk);
      if (rstReq) begin
        if (prevReq) dbl = 1;
        if (firstE == 0) firstE = e;
        else if (secondE == 0) secondE = e;
      end
      prevReq = rstReq;
    end
    svcWr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int f;
    int s;
    int d;

    // R10: request low while reset is held
    @(negedge clk);
    check("R10 reset state", int'(rstReq), 0);

    foreach (VECS[i]) begin
      doReset(VECS[i].en, VECS[i].sel);
      runSeq(VECS[i].d1, int'(VECS[i].e1), VECS[i].d2, int'(VECS[i].e2),
             VECS[i].d3, int'(VECS[i].e3), MAX_EDGES, f, s, d);
      check($sformatf("R%0d vector %0d first request edge", VECS[i].req, i),
            f, int'(VECS[i].expFirst));
    end

    // R10: reset mid-count with the sequence armed clears both
    doReset(1'b1, 2'd1);
    runSeq(8'h55, 3, 8'h00, 0, 8'h00, 0, 10, f, s, d);
    check("R10 no request before reset", f, 0);
    doReset(1'b1, 2'd1);
    runSeq(8'hAA, 3, 8'h00, 0, 8'h00, 0, 40, f, s, d);
    check("R10 count and key cleared by reset", f, 16);

    // R9, R11: free-running timeouts repeat at full period, one cycle each
    doReset(1'b1, 2'd1);
    runSeq(8'h00, 0, 8'h00, 0, 8'h00, 0, 40, f, s, d);
    check("R11 first timeout", f, 16);
    check("R11 second timeout full period later", s, 32);
    check("R9 pulse one cycle", d, 0);

    // R9: back-to-back bad writes never widen the pulse
    doReset(1'b1, 2'd1);
    runSeq(8'h12, 3, 8'h34, 4, 8'h00, 0, 10, f, s, d);
    check("R9 first bad write request", f, 3);
    check("R9 no two-cycle request", d, 0);

    // R11: key progress cleared by a timeout request
    doReset(1'b1, 2'd1);
    runSeq(8'h55, 3, 8'hAA, 18, 8'h00, 0, 40, f, s, d);
    check("R11 timeout with armed key", f, 16);
    check("R11 key lost after request", s, 32);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule